// File: doc/BRIEF.md
# Phase-Frequency Comparator with Reversible Polarity

This block compares the rising edges of a divided reference (`ref_in`) and a divided feedback signal (`fb_in`), both sampled on the system clock. A rising edge on the reference raises an internal lead flag. A rising edge on the feedback raises an internal lag flag. Once both flags are up, they stay up together for a programmable number of overlap cycles and are then cleared together. The overlap removes the dead zone around zero phase error. A flag is never cleared by a second edge on the same input, which gives the comparator a range of one full input period either way.

The two flags are decoded into several outputs:
- a pump command for the main loop (source and sink enables; both low means high impedance);
- a copy of that command for a bypass pump, gated by `aux_en`;
- two logic-level outputs for an external pump;
- an active-high in-phase indicator;
- a monitor output that shows one of the two divided inputs.

`pol_norm` reverses the sense of every error output, to suit a VCO whose tuning slope has the opposite sign. It also selects which input appears on the monitor.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `phase_freq_cmp`

## Requirements
- R1: After reset the block is idle: `pump_src`=0, `pump_snk`=0, `ext_a`=0, `ext_b`=1, `in_phase`=1, `aux_src`=0, `aux_snk`=0.
- R2: A rising edge on `ref_in` sets the lead flag, and a rising edge on `fb_in` sets the lag flag, at the clock edge that samples the new high level. A set flag persists until both flags are set. Both then stay set for exactly OVERLAP cycles and clear together at the following clock edge.
- R3: With `pol_norm`=1, the outputs follow the flags:
  - lead flag only: `pump_src`=1, `pump_snk`=0, `ext_a`=0, `ext_b`=0;
  - lag flag only: `pump_src`=0, `pump_snk`=1, `ext_a`=1, `ext_b`=1.
- R4: With `pol_norm`=0, the outputs follow the flags:
  - lead flag only: `pump_src`=0, `pump_snk`=1, `ext_a`=1, `ext_b`=1;
  - lag flag only: `pump_src`=1, `pump_snk`=0, `ext_a`=0, `ext_b`=0.
- R5: For either value of `pol_norm`:
  - no flag set: both pump enables are 0, `ext_a`=0 and `ext_b`=1;
  - both flags set (the overlap): both pump enables are 1, `ext_a`=1 and `ext_b`=0.
- R6: `in_phase` is the NOR of the two flags. It is 1 when neither flag is set and 0 while any error pulse is present.
- R7: `mon_out` equals `ref_in` when `pol_norm`=1 and `fb_in` when `pol_norm`=0, delayed by one clock.
- R8: When `aux_en`=1, `aux_src` and `aux_snk` equal `pump_src` and `pump_snk`. When `aux_en`=0, both are 0 (high impedance), whatever the flags are.
- R9: With equal input frequencies and a lag of half a period, the one-sided error pulse lasts half the period in clock cycles. More generally, the one-sided part of the pulse equals the edge separation in cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided reference signal |
| fb_in | input | 1 | Divided feedback (VCO) signal |
| pol_norm | input | 1 | 1 = normal polarity and monitor shows reference; 0 = reversed polarity and monitor shows feedback |
| aux_en | input | 1 | Enables the bypass pump copy |
| pump_src | output | 1 | Main pump source enable |
| pump_snk | output | 1 | Main pump sink enable |
| aux_src | output | 1 | Bypass pump source enable |
| aux_snk | output | 1 | Bypass pump sink enable |
| ext_a | output | 1 | External pump drive A, idle low |
| ext_b | output | 1 | External pump drive B, idle high |
| in_phase | output | 1 | 1 when no error pulse is active |
| mon_out | output | 1 | Selected divided input, one cycle late |

## Verification
Two things can fall in the same cycle: the lead edge and the lag edge, which then set both flags together and start the overlap at once. The bench provokes this with scenarios of zero edge separation under both polarities. It judges the result cycle by cycle: both pump enables must be high for exactly OVERLAP cycles with no one-sided pulse before them, and `in_phase` must return high on the next cycle. Scenarios with nonzero separation and with the lag input leading check that the one-sided width tracks the separation, including the half-period case.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Command to one charge pump: both low means high impedance.
  typedef struct packed {
    logic src;
    logic snk;
  } pump_cmd_t;

  // Drive levels for an external pump pair.
  typedef struct packed {
    logic a;
    logic b;
  } ext_drv_t;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic sig_q,
  output logic rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  // A rising edge is a high level now after a low level last cycle.
  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core #(
  parameter int OVERLAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lead_set,
  input  logic lag_set,
  output logic lead_flag,
  output logic lag_flag
);
  localparam int CW = (OVERLAP < 2) ? 1 : $clog2(OVERLAP);
  localparam logic [CW-1:0] LAST = CW'(OVERLAP - 1);

  logic [CW-1:0] ovl_cnt;
  logic          both;

  assign both = lead_flag & lag_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_flag <= 1'b0;
      lag_flag  <= 1'b0;
      ovl_cnt   <= '0;
    end else if (both) begin
      // Overlap phase: edges arriving now are not captured.
      if (ovl_cnt == LAST) begin
        lead_flag <= 1'b0;
        lag_flag  <= 1'b0;
        ovl_cnt   <= '0;
      end else begin
        ovl_cnt <= ovl_cnt + 1'b1;
      end
    end else begin
      lead_flag <= lead_flag | lead_set;
      lag_flag  <= lag_flag | lag_set;
    end
  end
endmodule

// File: rtl/pfd_out_map.sv
module pfd_out_map
  import pfd_pkg::*;
(
  input  logic      lead_flag,
  input  logic      lag_flag,
  input  logic      pol_norm,
  input  logic      aux_en,
  input  logic      ref_q,
  input  logic      fb_q,
  output pump_cmd_t main_cmd,
  output pump_cmd_t aux_cmd,
  output ext_drv_t  ext_drv,
  output logic      in_phase,
  output logic      mon_out
);
  logic up_eff, dn_eff;

  // The polarity control swaps the roles of the two flags.
  assign up_eff = pol_norm ? lead_flag : lag_flag;
  assign dn_eff = pol_norm ? lag_flag  : lead_flag;

  always_comb begin
    main_cmd.src = up_eff;
    main_cmd.snk = dn_eff;
    aux_cmd.src  = aux_en & up_eff;
    aux_cmd.snk  = aux_en & dn_eff;
    ext_drv.a    = dn_eff;
    ext_drv.b    = ~up_eff;
  end

  assign in_phase = ~(lead_flag | lag_flag);
  assign mon_out  = pol_norm ? ref_q : fb_q;
endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
  import pfd_pkg::*;
#(
  parameter int OVERLAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic pol_norm,
  input  logic aux_en,
  output logic pump_src,
  output logic pump_snk,
  output logic aux_src,
  output logic aux_snk,
  output logic ext_a,
  output logic ext_b,
  output logic in_phase,
  output logic mon_out
);
  localparam int NIN = 2;

  logic [NIN-1:0] raw_in, in_q, in_rise;
  logic           lead_flag, lag_flag;
  pump_cmd_t      main_cmd, aux_cmd;
  ext_drv_t       ext_drv;

  assign raw_in = {fb_in, ref_in};

  for (genvar gi = 0; gi < NIN; gi++) begin : g_edge
    pfd_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (raw_in[gi]),
      .sig_q  (in_q[gi]),
      .rise   (in_rise[gi])
    );
  end

  pfd_flag_core #(.OVERLAP(OVERLAP)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .lead_set  (in_rise[0]),
    .lag_set   (in_rise[1]),
    .lead_flag (lead_flag),
    .lag_flag  (lag_flag)
  );

  pfd_out_map u_map (
    .lead_flag (lead_flag),
    .lag_flag  (lag_flag),
    .pol_norm  (pol_norm),
    .aux_en    (aux_en),
    .ref_q     (in_q[0]),
    .fb_q      (in_q[1]),
    .main_cmd  (main_cmd),
    .aux_cmd   (aux_cmd),
    .ext_drv   (ext_drv),
    .in_phase  (in_phase),
    .mon_out   (mon_out)
  );

  assign pump_src = main_cmd.src;
  assign pump_snk = main_cmd.snk;
  assign aux_src  = aux_cmd.src;
  assign aux_snk  = aux_cmd.snk;
  assign ext_a    = ext_drv.a;
  assign ext_b    = ext_drv.b;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int OVERLAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic aux_en,
  input logic pump_src,
  input logic pump_snk,
  input logic aux_src,
  input logic aux_snk,
  input logic ext_a,
  input logic ext_b,
  input logic in_phase
);
  logic [15:0] both_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 both_run <= '0;
    else if (pump_src && pump_snk) begin
      if (both_run != 16'hFFFF) both_run <= both_run + 1'b1;
    end else                    both_run <= '0;
  end

  // R2
  overlap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && pump_snk) |-> (both_run < 16'(OVERLAP)));

  // R5
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_src && !pump_snk) |-> (!ext_a && ext_b));

  // R5
  overlap_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && pump_snk) |-> (ext_a && !ext_b));

  // R6
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_phase |-> (!pump_src && !pump_snk));

  // R8
  aux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_en |-> (!aux_src && !aux_snk));

  // R8
  aux_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |-> (aux_src == pump_src && aux_snk == pump_snk));
endmodule

bind phase_freq_cmp pfd_checker #(.OVERLAP(OVERLAP)) u_chk (.*);

// File: tb/phase_freq_cmp_tb.sv
module phase_freq_cmp_tb;
  localparam int OV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0, pol_norm = 1'b1, aux_en = 1'b0;
  logic pump_src, pump_snk, aux_src, aux_snk, ext_a, ext_b, in_phase, mon_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  up;
    logic  dn;
    logic  pol;
    logic  aux;
    logic  mon;
    string tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  phase_freq_cmp #(.OVERLAP(OV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pol_norm(pol_norm), .aux_en(aux_en),
    .pump_src(pump_src), .pump_snk(pump_snk),
    .aux_src(aux_src), .aux_snk(aux_snk),
    .ext_a(ext_a), .ext_b(ext_b), .in_phase(in_phase), .mon_out(mon_out)
  );

  task automatic cmp(string tag, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Scoreboard side: expected outputs from the requirement tables
  // (R3, R4, R5, R6, R7, R8).
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic s, k, a, b;
        e = q.pop_front();
        if (e.up && e.dn)       begin s = 1; k = 1; a = 1; b = 0; end
        else if (!e.up && !e.dn) begin s = 0; k = 0; a = 0; b = 1; end
        else if (e.up == e.pol) begin s = 1; k = 0; a = 0; b = 0; end
        else                     begin s = 0; k = 1; a = 1; b = 1; end
        cmp(e.tag, "pump_src", pump_src, s);
        cmp(e.tag, "pump_snk", pump_snk, k);
        cmp(e.tag, "ext_a", ext_a, a);
        cmp(e.tag, "ext_b", ext_b, b);
        cmp(e.tag, "in_phase R6", in_phase, !(e.up || e.dn));
        cmp(e.tag, "aux_src R8", aux_src, e.aux & s);
        cmp(e.tag, "aux_snk R8", aux_snk, e.aux & k);
        cmp(e.tag, "mon_out R7", mon_out, e.mon);
      end
    end
  end

  // One clock: drive levels at the falling edge, expect flags after the next rise.
  task automatic step(logic r, logic f, logic u, logic d, string tag);
    exp_t e;
    @(negedge clk);
    ref_in = r;
    fb_in  = f;
    e.up = u; e.dn = d; e.pol = pol_norm; e.aux = aux_en;
    e.mon = pol_norm ? r : f;
    e.tag = tag;
    q.push_back(e);
  endtask

  // One comparison period: the leading input rises at k=0, the lagging one
  // at k=sep; both fall when the overlap ends (R2, R9).
  task automatic scen(logic pol, logic aux, logic ref_leads, int sep, int period, string tag);
    @(negedge clk);
    pol_norm = pol;
    aux_en   = aux;
    for (int k = 0; k < period; k++) begin
      logic lead_lvl, lag_lvl, fl, bl;
      lead_lvl = (k < sep + OV);
      lag_lvl  = (k >= sep) && (k < sep + OV);
      fl = (k < sep + OV);
      bl = (k >= sep) && (k < sep + OV);
      if (ref_leads) step(lead_lvl, lag_lvl, fl, bl, tag);
      else           step(lag_lvl, lead_lvl, bl, fl, tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle state out of reset
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    // R3, R2: reference leads by 3 under normal polarity
    scen(1, 1, 1, 3, 10, "R3");
    // R3: feedback leads (fp faster)
    scen(1, 1, 0, 4, 10, "R3");
    // R4: reversed polarity, both orders
    scen(0, 1, 1, 3, 10, "R4");
    scen(0, 1, 0, 5, 10, "R4");
    // R5: coincident edges, both polarities
    scen(1, 1, 1, 0, 6, "R5");
    scen(0, 1, 0, 0, 6, "R5");
    // R8: bypass copy disabled while errors occur
    scen(1, 0, 1, 4, 10, "R8");
    scen(0, 0, 0, 2, 8, "R8");
    // R9: equal periods of 16, lag of half a period
    for (int i = 0; i < 3; i++) scen(1, 1, 1, 8, 16, "R9");
    // R2: drifting separation, as with a frequency offset
    for (int sep = 1; sep < 7; sep++) scen(1, 1, 0, sep, sep + OV + 3, "R2");
    // R7: monitor on both selections with idle toggling cut short
    scen(1, 1, 1, 1, 5, "R7");
    scen(0, 1, 1, 1, 5, "R7");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule